// File: doc/BRIEF.md
# Clocked Serial Slave Transmitter

This block sends words out of a chip on a single data line. The shift clock comes from the far end of the link, not from this block. Software writes a word into a holding register. If the shifter is idle, the word moves straight into it and leaves least-significant bit first, one bit per selected edge of the external clock. A word written while another is still going out waits in the holding register. The buffer-empty flag stays low until that waiting word has been handed to the shifter.

Frames are 8 data bits wide, or 9 when the long-frame input is set at the time of the write. The extra top bit is taken from a separate ninth-bit input. The external clock is brought into the system clock domain through a two-stage synchronizer with edge detection, so the system clock must run at least four times faster than the shift clock. The interrupt request is a purely combinational product of the buffer-empty flag and its enable, so it can still signal while the system clock is stopped. A status output shows whether the shifter is empty.

Top module: `sync_slave_tx`

## Requirements
- R1: The port is active only when `sync_mode` and `port_en` are both 1 and `master_sel`, `rx_single_en` and `rx_cont_en` are all 0. A write (`wr_stb`) is accepted only while the port is active and `tx_en` is 1. Any other write has no effect on `sdo`, `buf_empty` or `shift_empty`.
- R2: When the shifter is empty, an accepted write loads the word into the shifter at once. Bit 0 is on `sdo` at the next clock, `shift_empty` goes to 0, and `buf_empty` stays 1.
- R3: A write accepted while a frame is shifting is kept in the holding register and `buf_empty` reads 0. When the active edge that ends the current frame arrives, the held word enters the shifter, its bit 0 appears on `sdo`, and `buf_empty` returns to 1.
- R4: Bits leave least-significant bit first, and `sdo` advances one bit per active edge. With `clk_pol`=0 the active edge is the falling edge of `sclk_in`; with `clk_pol`=1 it is the rising edge. A frame of N bits takes exactly N active edges. After the last one, with nothing held, `sdo` idles at 1 and `shift_empty` is 1.
- R5: When `frame9` is 1 at the time of the write, the frame is 9 bits long and its last bit is the value `bit9` had at the write. When `frame9` is 0, the frame is 8 bits long.
- R6: `tx_irq` equals `buf_empty` AND `tx_int_en`, with no clock involved.
- R7: Making the port inactive or clearing `tx_en` aborts any frame and drops any held word. From the next clock, `shift_empty` and `buf_empty` are 1 and `sdo` is 1.
- R8: After reset, `sdo`, `buf_empty` and `shift_empty` are 1.
- R9: A write accepted while a word is already held replaces the held word; the replaced word is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | External shift clock |
| sync_mode | input | 1 | Synchronous mode select |
| port_en | input | 1 | Serial port enable |
| master_sel | input | 1 | Master select; must be 0 for this block to run |
| rx_single_en | input | 1 | Single receive enable; must be 0 |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 |
| tx_en | input | 1 | Transmit enable |
| clk_pol | input | 1 | Active shift edge: 0 falling, 1 rising |
| frame9 | input | 1 | Nine-bit frame select, captured at write |
| bit9 | input | 1 | Ninth data bit, captured at write |
| tx_int_en | input | 1 | Interrupt enable for buffer-empty |
| wr_stb | input | 1 | Data write strobe |
| wr_data | input | DW | Data word |
| sdo | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shifter empty status |
| tx_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default `DW`=8, so both the 8-bit and the 9-bit frame lengths are covered. Each phase of the external clock lasts six system clocks. That leaves room for the two-stage synchronizer and still lets `sdo` be sampled on the edge opposite the shifting one. Random words, frame lengths, polarities and one- or two-word bursts are mixed with directed cases. The directed cases cover writes while disabled, an abort in mid-frame, replacement of a held word, and a ninth bit changed after its write.

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  input  logic          sync_mode,
  input  logic          port_en,
  input  logic          master_sel,
  input  logic          rx_single_en,
  input  logic          rx_cont_en,
  input  logic          tx_en,
  input  logic          clk_pol,
  input  logic          frame9,
  input  logic          bit9,
  input  logic          tx_int_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          buf_empty,
  output logic          shift_empty,
  output logic          tx_irq
);
  localparam int FW = DW + 1;
  localparam int CW = $clog2(FW + 1);

  logic          run, accept, shift_evt, done, free;
  logic [2:0]    sclk_q;
  logic [FW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [DW-1:0] hold_data;
  logic          hold9, hold_n9, hold_full;

  assign run    = sync_mode & port_en & ~master_sel & ~rx_single_en & ~rx_cont_en & tx_en;
  assign accept = run & wr_stb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= '0;
    else        sclk_q <= {sclk_q[1:0], sclk_in};

  assign shift_evt = clk_pol ? (sclk_q[1] & ~sclk_q[2]) : (~sclk_q[1] & sclk_q[2]);
  assign done      = busy & shift_evt & (cnt == CW'(1));
  assign free      = ~busy | (done & ~hold_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      hold_data <= '0;
      hold9     <= 1'b0;
      hold_n9   <= 1'b0;
      hold_full <= 1'b0;
    end else if (!run) begin
      busy      <= 1'b0;
      cnt       <= '0;
      hold_full <= 1'b0;
    end else begin
      if (busy && shift_evt) begin
        if (cnt == CW'(1)) begin
          if (hold_full) begin
            shreg     <= {hold9, hold_data};
            cnt       <= hold_n9 ? CW'(FW) : CW'(DW);
            hold_full <= 1'b0;
          end else begin
            busy <= 1'b0;
            cnt  <= '0;
          end
        end else begin
          shreg <= shreg >> 1;
          cnt   <= cnt - CW'(1);
        end
      end
      if (accept) begin
        if (free) begin
          shreg <= {bit9 & frame9, wr_data};
          cnt   <= frame9 ? CW'(FW) : CW'(DW);
          busy  <= 1'b1;
        end else begin
          hold_data <= wr_data;
          hold9     <= bit9 & frame9;
          hold_n9   <= frame9;
          hold_full <= 1'b1;
        end
      end
    end
  end

  assign sdo         = busy ? shreg[0] : 1'b1;
  assign shift_empty = ~busy;
  assign buf_empty   = ~hold_full;
  assign tx_irq      = buf_empty & tx_int_en;

  a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (shift_empty && buf_empty));
  a_r1_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && shift_empty) |=> shift_empty);
  a_r3_hold_implies_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_empty |-> !shift_empty);
  a_r4_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> sdo);
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0 && cnt <= CW'(FW)));
  a_r2_shift_waits_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift_evt) |=> $stable(shreg));
endmodule

// File: tb/test_sync_slave_tx.sv
module test_sync_slave_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_in = 1'b0, sync_mode = 1'b1, port_en = 1'b1, master_sel = 1'b0;
  logic rx_single_en = 1'b0, rx_cont_en = 1'b0, tx_en = 1'b1, clk_pol = 1'b0;
  logic frame9 = 1'b0, bit9 = 1'b0, tx_int_en = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic sdo, buf_empty, shift_empty, tx_irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sync_slave_tx #(.DW(8)) i_sync_slave_tx (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sync_mode(sync_mode),
    .port_en(port_en), .master_sel(master_sel), .rx_single_en(rx_single_en),
    .rx_cont_en(rx_cont_en), .tx_en(tx_en), .clk_pol(clk_pol), .frame9(frame9),
    .bit9(bit9), .tx_int_en(tx_int_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .sdo(sdo), .buf_empty(buf_empty), .shift_empty(shift_empty), .tx_irq(tx_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic frame_bit(input logic [7:0] d, input logic b9, input int i);
    return (i < 8) ? d[i] : b9;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk);
    clk_pol = p;
    sclk_in = p;
    wait_clk(6);
  endtask

  task automatic write_word(input logic [7:0] d, input logic n9, input logic b9);
    @(negedge clk);
    wr_data = d; frame9 = n9; bit9 = b9; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic bit_cycle(input logic exp, input string req);
    @(negedge clk);
    sclk_in = ~clk_pol;
    check(req, 32'(sdo), 32'(exp));
    wait_clk(6);
    sclk_in = clk_pol;
    wait_clk(6);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic n9, input logic b9,
                            input logic more_held, input string req);
    int len;
    len = n9 ? 9 : 8;
    for (int i = 0; i < len; i++) begin
      bit_cycle(frame_bit(d, b9, i), req);
      if (more_held && i < len - 1) check("R3 held word keeps buf_empty low", 32'(buf_empty), 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    wait_clk(3);
    check("R8 reset sdo", 32'(sdo), 32'd1);
    check("R8 reset buf_empty", 32'(buf_empty), 32'd1);
    check("R8 reset shift_empty", 32'(shift_empty), 32'd1);
    rst_n = 1'b1;
    wait_clk(6);
    tx_int_en = 1'b1;
    #1 check("R6 irq with empty buffer", 32'(tx_irq), 32'd1);
    tx_int_en = 1'b0;
    #1 check("R6 irq masked", 32'(tx_irq), 32'd0);

    // R1: writes ignored under each disabling condition
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: tx_en = 1'b0;
        1: master_sel = 1'b1;
        2: rx_cont_en = 1'b1;
        3: rx_single_en = 1'b1;
        4: sync_mode = 1'b0;
        default: port_en = 1'b0;
      endcase
      write_word(8'h00, 1'b0, 1'b0);
      check("R1 disabled write shift_empty", 32'(shift_empty), 32'd1);
      check("R1 disabled write sdo", 32'(sdo), 32'd1);
      tx_en = 1'b1; master_sel = 1'b0; rx_cont_en = 1'b0; rx_single_en = 1'b0;
      sync_mode = 1'b1; port_en = 1'b1;
      wait_clk(2);
    end

    // R7: abort in mid-frame, then a clean frame
    set_pol(1'b0);
    write_word(8'hA5, 1'b0, 1'b0);
    write_word(8'h3C, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) bit_cycle(frame_bit(8'hA5, 1'b0, i), "R4 bits before abort");
    @(negedge clk); tx_en = 1'b0;
    wait_clk(1);
    check("R7 abort shift_empty", 32'(shift_empty), 32'd1);
    check("R7 abort buf_empty", 32'(buf_empty), 32'd1);
    check("R7 abort sdo", 32'(sdo), 32'd1);
    tx_en = 1'b1;
    wait_clk(2);
    write_word(8'h96, 1'b0, 1'b0);
    send_frame(8'h96, 1'b0, 1'b0, 1'b0, "R7 frame after abort");
    check("R7 no leftover after abort", 32'(shift_empty), 32'd1);

    // R9: held word replaced
    write_word(8'h11, 1'b0, 1'b0);
    write_word(8'h22, 1'b0, 1'b0);
    write_word(8'hE7, 1'b1, 1'b1);
    send_frame(8'h11, 1'b0, 1'b0, 1'b1, "R9 first frame");
    send_frame(8'hE7, 1'b1, 1'b1, 1'b0, "R9 replacing word sent");
    check("R9 replaced word dropped", 32'(shift_empty), 32'd1);

    // R5: ninth bit captured at write
    set_pol(1'b1);
    write_word(8'h5A, 1'b1, 1'b1);
    bit9 = 1'b0; frame9 = 1'b0;
    send_frame(8'h5A, 1'b1, 1'b1, 1'b0, "R5 ninth bit from write time");
    check("R5 done after nine", 32'(shift_empty), 32'd1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] d1, d2;
      logic n1, n2, b1, b2, two;
      d1 = 8'($urandom); d2 = 8'($urandom);
      n1 = 1'($urandom); n2 = 1'($urandom);
      b1 = 1'($urandom); b2 = 1'($urandom);
      two = 1'($urandom);
      set_pol(1'($urandom));
      tx_int_en = 1'($urandom);
      write_word(d1, n1, b1);
      check("R2 load on idle shift_empty", 32'(shift_empty), 32'd0);
      check("R2 load on idle buf_empty", 32'(buf_empty), 32'd1);
      check("R6 irq follows flag", 32'(tx_irq), 32'(tx_int_en));
      if (two) begin
        write_word(d2, n2, b2);
        check("R3 second word held", 32'(buf_empty), 32'd0);
        check("R6 irq low while held", 32'(tx_irq), 32'd0);
      end
      send_frame(d1, n1, b1, two, "R4 first frame bits");
      if (two) begin
        check("R3 buf_empty after hand-over", 32'(buf_empty), 32'd1);
        check("R3 second frame started", 32'(shift_empty), 32'd0);
        send_frame(d2, n2, b2, 1'b0, "R3 second frame bits");
      end
      check("R4 idle after last bit", 32'(shift_empty), 32'd1);
      check("R4 idle line", 32'(sdo), 32'd1);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule